// File: doc/BRIEF.md
# Pin Edge Event Latch with Combined Interrupt

This block samples a 32-bit general-purpose input port and latches edge events per pin. Each pin has two sticky flags: one set by a rising edge and one set by a falling edge. A flag can only be set while its per-pin enable is on. Software reads both flag words over a small register port and acknowledges events through a write-only acknowledge word. Writing 1 to bit n of that word drops both flags of pin n in one write. A single registered interrupt line is high whenever any flag is set.

Pins are asynchronous to the block clock. They pass through a synchroniser chain, and an edge is found by comparing the synchronised level with its value one cycle earlier. The register port is single-cycle. Read data is combinational from the address. A write takes effect at the clock edge on which `wr_i` is high.

Top module: `gpio_edge_irq`

## Requirements
- R1: The port is 32 pins wide, and bit n of every flag, enable and acknowledge word belongs to pin n (bit 0 is pin 0, bit 31 is pin 31).
- R2: Once pin n goes from 0 to 1 with its rising enable set, bit n of the rising-flag word (address 2, read-only) reads 1 three clock edges after the new level is presented. It then stays 1 until it is acknowledged.
- R3: Once pin n goes from 1 to 0 with its falling enable set, bit n of the falling-flag word (address 3, read-only) reads 1 three clock edges after the new level is presented. It then stays 1 until it is acknowledged.
- R4: After reset, both flag words, both enable words and the interrupt line are 0.
- R5: Writing 1 to bit n of the acknowledge word (address 4) clears both flags of pin n at that clock edge. A 0 bit leaves both flags of that pin as they were.
- R6: A flag is never set while its enable bit is 0. Turning an enable off does not clear a flag that is already set.
- R7: The rising-enable word (address 0) and the falling-enable word (address 1) are read/write and read back the last value written.
- R8: If an acknowledge of pin n falls on the same clock edge at which a new enabled edge of pin n is recorded, the flag ends up set.
- R9: Reads of address 4 and of unmapped addresses 5 to 7 return 0. Writes to addresses 2 and 3 change nothing.
- R10: The interrupt output at each clock edge equals the OR of all bits of both flag words as they were just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32 | Asynchronous input pins |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Registered OR of all edge flags |

## Verification
Two actions can land on the same clock edge: recording a newly detected edge on a pin and acknowledging that same pin. The bench provokes this directly. It raises a pin that is already flagged and issues the acknowledge write exactly in the cycle the edge is detected. Random pin toggles also mix with random acknowledge writes, so the overlap recurs many times. A reference model that keeps the pin history as a queue recomputes the expected flags every clock, and each outcome is checked against it. Under that model the flag must survive the collision and the interrupt must stay high.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RISE_EN  = 3'd0,
    SEL_FALL_EN  = 3'd1,
    SEL_RISE_FLG = 3'd2,
    SEL_FALL_FLG = 3'd3,
    SEL_ACK      = 3'd4
  } reg_sel_e;

  // rising when now high and one cycle earlier low
  function automatic logic rose(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  function automatic logic fell(input logic now_v, input logic was_v);
    return ~now_v & was_v;
  endfunction

  // next flag value: acknowledge first, a fresh enabled edge overrides
  function automatic logic flag_next(input logic cur, input logic ack,
                                     input logic evt, input logic en);
    return (cur & ~ack) | (evt & en);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_edge_track.sv
module gpio_edge_track
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] rise_evt_o,
  output logic [W-1:0] fall_evt_o,
  output logic [W-1:0] rise_flg_o,
  output logic [W-1:0] fall_flg_o
);

  logic [W-1:0] lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign rise_evt_o[i] = rose(lvl_i[i], lvl_prev[i]);
    assign fall_evt_o[i] = fell(lvl_i[i], lvl_prev[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_flg_o[i] <= 1'b0;
        fall_flg_o[i] <= 1'b0;
      end else begin
        rise_flg_o[i] <= flag_next(rise_flg_o[i], ack_i[i], rise_evt_o[i], rise_en_i[i]);
        fall_flg_o[i] <= flag_next(fall_flg_o[i], ack_i[i], fall_evt_o[i], fall_en_i[i]);
      end
    end
  end

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      rise_flg_i,
  input  logic [W-1:0]      fall_flg_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      rise_en_o,
  output logic [W-1:0]      fall_en_o,
  output logic [W-1:0]      ack_o
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
    end else if (wr_i) begin
      if (sel == SEL_RISE_EN) rise_en_o <= wdata_i;
      if (sel == SEL_FALL_EN) fall_en_o <= wdata_i;
    end
  end

  assign ack_o = (wr_i && sel == SEL_ACK) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_RISE_EN:  rdata_o = rise_en_o;
      SEL_FALL_EN:  rdata_o = fall_en_o;
      SEL_RISE_FLG: rdata_o = rise_flg_i;
      SEL_FALL_FLG: rdata_o = fall_flg_i;
      default:      rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [PINS-1:0]   wdata_i,
  output logic [PINS-1:0]   rdata_o,
  output logic              irq_o
);

  logic [PINS-1:0] lvl;
  logic [PINS-1:0] rise_evt, fall_evt;
  logic [PINS-1:0] rise_flg, fall_flg;
  logic [PINS-1:0] rise_en, fall_en;
  logic [PINS-1:0] ack;

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (lvl)
  );

  gpio_edge_track #(.W(PINS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl),
    .rise_en_i  (rise_en),
    .fall_en_i  (fall_en),
    .ack_i      (ack),
    .rise_evt_o (rise_evt),
    .fall_evt_o (fall_evt),
    .rise_flg_o (rise_flg),
    .fall_flg_o (fall_flg)
  );

  gpio_edge_regs #(.W(PINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rise_flg_i (rise_flg),
    .fall_flg_i (fall_flg),
    .rdata_o    (rdata_o),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en),
    .ack_o      (ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(rise_flg | fall_flg);
  end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] rise_evt,
  input logic [W-1:0] fall_evt,
  input logic [W-1:0] rise_en,
  input logic [W-1:0] fall_en,
  input logic [W-1:0] ack,
  input logic [W-1:0] rise_flg,
  input logic [W-1:0] fall_flg,
  input logic         irq_o
);

  // R6
  rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_flg & ~$past(rise_flg)) & ~$past(rise_evt & rise_en)) == '0);

  // R6
  fall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_flg & ~$past(fall_flg)) & ~$past(fall_evt & fall_en)) == '0);

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack) & ~$past(rise_evt & rise_en) & rise_flg) == '0);

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack & fall_evt & fall_en) & ~fall_flg) == '0);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rise_flg) & ~$past(ack) & ~rise_flg) == '0);

  // R3
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt & fall_evt) == '0);

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(rise_flg | fall_flg)));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.W(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise_evt (rise_evt),
  .fall_evt (fall_evt),
  .rise_en  (rise_en),
  .fall_en  (fall_en),
  .ack      (ack),
  .rise_flg (rise_flg),
  .fall_flg (fall_flg),
  .irq_o    (irq_o)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk (clk), .rst_n (rst_n), .pins_i (pins), .addr_i (addr),
    .wr_i (wr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  // behavioural reference
  logic [31:0] m_ren, m_fen, m_rf, m_ff;
  logic        m_irq;
  logic [31:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ren = 0; m_fen = 0; m_rf = 0; m_ff = 0; m_irq = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] up, dn, clr;
      m_irq = (m_rf != 0) || (m_ff != 0);
      up  = hist[1] & ~hist[2];
      dn  = ~hist[1] & hist[2];
      clr = (wr && addr == 3'd4) ? wdata : 32'h0;
      m_rf = (m_rf & ~clr) | (up & m_ren);
      m_ff = (m_ff & ~clr) | (dn & m_fen);
      if (wr && addr == 3'd0) m_ren = wdata;
      if (wr && addr == 3'd1) m_fen = wdata;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ren;
      3'd1: return m_fen;
      3'd2: return m_rf;
      3'd3: return m_ff;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R7";
      3'd2: return "R2";
      3'd3: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: compare irq, drive inputs, compare read data
  task automatic cyc(input logic [31:0] p, input logic [2:0] a,
                     input logic w, input logic [31:0] d);
    @(negedge clk);
    check("R10", {31'b0, irq}, {31'b0, m_irq});
    pins = p; addr = a; wr = w; wdata = d;
    #1;
    check(tag_of(a), rdata, m_read(a));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] p;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R4: reset state
    for (int a = 0; a < 5; a++) begin
      cyc(0, 3'(a), 0, 0);
      check("R4", rdata, 32'h0);
    end
    check("R4", {31'b0, irq}, 32'h0);

    // R7: enable readback
    cyc(0, 3'd0, 1, 32'h8000_0021);
    cyc(0, 3'd1, 1, 32'h8000_0001);
    cyc(0, 3'd0, 0, 0); check("R7", rdata, 32'h8000_0021);
    cyc(0, 3'd1, 0, 0); check("R7", rdata, 32'h8000_0001);

    // R2 / R1: rise on pins 0, 5, 31
    p = 32'h8000_0021;
    cyc(p, 3'd2, 0, 0);
    cyc(p, 3'd2, 0, 0);
    cyc(p, 3'd2, 0, 0); check("R2", rdata, 32'h0);
    cyc(p, 3'd2, 0, 0); check("R1", rdata, 32'h8000_0021);
    cyc(p, 3'd3, 0, 0); check("R10", {31'b0, irq}, 32'h1);

    // R6: drop pin 5 with no falling enable; pins 0 and 31 fall enabled
    p = 32'h0;
    cyc(p, 3'd3, 0, 0);
    cyc(p, 3'd3, 0, 0);
    cyc(p, 3'd3, 0, 0);
    cyc(p, 3'd3, 0, 0); check("R3", rdata, 32'h8000_0001);
    // R9: status writes ignored
    cyc(p, 3'd2, 1, 32'h0);
    cyc(p, 3'd3, 1, 32'h0);
    cyc(p, 3'd2, 0, 0); check("R9", rdata, 32'h8000_0021);
    cyc(p, 3'd3, 0, 0); check("R9", rdata, 32'h8000_0001);
    // R6: disabling keeps flags
    cyc(p, 3'd0, 1, 32'h0);
    cyc(p, 3'd2, 0, 0); check("R6", rdata, 32'h8000_0021);
    // R5: ack pin 31 clears both its flags, 0 bits untouched
    cyc(p, 3'd4, 1, 32'h8000_0000); check("R9", rdata, 32'h0);
    cyc(p, 3'd2, 0, 0); check("R5", rdata, 32'h0000_0021);
    cyc(p, 3'd3, 0, 0); check("R5", rdata, 32'h0000_0001);
    cyc(p, 3'd6, 0, 0); check("R9", rdata, 32'h0);

    // R8: re-enable rise on pin 5, edge coincides with ack
    cyc(p, 3'd0, 1, 32'h0000_0020);
    p = 32'h20;
    cyc(p, 3'd2, 0, 0);
    cyc(p, 3'd2, 0, 0);
    cyc(p, 3'd4, 1, 32'h0000_0021);
    cyc(p, 3'd2, 0, 0); check("R8", rdata, 32'h0000_0020);
    cyc(p, 3'd3, 0, 0); check("R8", rdata, 32'h0);
    // clear everything
    cyc(p, 3'd4, 1, 32'hFFFF_FFFF);
    cyc(p, 3'd2, 0, 0); check("R5", rdata, 32'h0);
    cyc(p, 3'd2, 0, 0); check("R10", {31'b0, irq}, 32'h0);

    // random phase against the model
    for (int k = 0; k < 5000; k++) begin
      int op;
      if ($urandom_range(0, 2) == 0) p = p ^ ($urandom & $urandom);
      op = $urandom_range(0, 11);
      case (op)
        0: cyc(p, 3'd0, 1, $urandom);
        1: cyc(p, 3'd1, 1, $urandom);
        2, 3: cyc(p, 3'd4, 1, $urandom);
        4: cyc(p, 3'(2 + $urandom_range(0, 1)), 1, $urandom);
        5: cyc(p, 3'd4, 1, 32'h0);
        default: cyc(p, 3'($urandom_range(0, 7)), 0, $urandom);
      endcase
    end
    cyc(p, 3'd0, 0, 0);
    finish_run();
  end

endmodule